// File: doc/BRIEF.md
# Memory-Mapped Request Router

This block sits between a single cache-side master and five memory-mapped slaves: a boot ROM, a core-local timer/interrupt unit, a platform interrupt controller, a UART and DRAM. For each request it compares the master's address against a fixed address map, forwards the request to the one slave that owns that range, waits for that slave to answer, and hands the answer back to the master. A write carries its address, data and strobe under one valid/ready pair, so address and data are always accepted together. The boot ROM and DRAM slave ports are 128 bits wide. The timer, interrupt-controller and UART ports are 32 bits wide and are steered onto one 32-bit lane of the 128-bit master bus.

Writes and reads each run their own state machine, so only one write and one read are open at any time. The write machine has these states. `WS_IDLE` accepts a request. It moves to one of `WS_CLINT`, `WS_PLIC`, `WS_UART` or `WS_DRAM` when the address maps to a writable slave. It moves straight to `WS_RESP` for a ROM write or an unmapped address. Each per-slave state first offers the write until the slave takes it, then waits for the slave's write response, then moves to `WS_RESP`. `WS_RESP` presents the status and returns to `WS_IDLE` once the master takes it.

The read machine runs `RS_IDLE`, `RS_ADDR`, `RS_DATA` and `RS_HOLD`. `RS_IDLE` accepts a request. It moves to `RS_ADDR` for a mapped address, or straight to `RS_HOLD` for an unmapped one. `RS_ADDR` offers the address until the slave takes it and then moves to `RS_DATA`. `RS_DATA` waits for read data and then moves to `RS_HOLD`. `RS_HOLD` presents the result and returns to `RS_IDLE` once the master takes it.

Top module: `mmio_router`

## Requirements
- R1: While reset is low and right after it, `m_wreq_ready` and `m_arready` are 1, and `m_bvalid`, `m_rvalid`, every bit of `s_wvalid` and every bit of `s_arvalid` are 0.
- R2: Slave index 0 is the boot ROM at 0x0001_0000..0x0001_1FFF. Index 1 is the timer unit at 0x0200_0000..0x020B_FFFF. Index 2 is the interrupt controller at 0x0C00_0000..0x0CFF_FFFF. Index 3 is the UART at 0x1000_0000..0x1000_00FF. Index 4 is DRAM from 0x8000_0000. A request inside a range goes to that index only.
- R3: Parameter `DRAM_LARGE` sets the last DRAM byte: 0x87FF_FFFF when 0 (the default) and 0x8FFF_FFFF when 1. Addresses above that limit are unmapped.
- R4: A write completes its master handshake on one valid/ready pair. The selected slave then sees `s_wvalid` with the master's address on `s_waddr`. A wide slave also gets the full 128-bit data and 16-bit strobe.
- R5: At most one bit of `s_wvalid` and at most one bit of `s_arvalid` is set in any cycle. Each forwarded request reaches exactly one slave.
- R6: For a write to a 32-bit slave, address bits [3:2] select lane k. `s_wdata_nar` is master data bits [32k+31:32k] and `s_wstrb_nar` is strobe bits [4k+3:4k].
- R7: Read data from a 32-bit slave returns on lane k of `m_rdata`, with k = address bits [3:2], and the other lanes are 0. Read data from a wide slave returns unchanged.
- R8: A write to the boot ROM, or any access outside the map, is answered with DECERR (2'b11) and is not forwarded: no `s_wvalid` or `s_arvalid` bit is raised. An unmapped read returns all-zero data.
- R9: After a request is accepted, that channel's master ready (`m_wreq_ready` or `m_arready`) stays 0 until the master completes the response handshake.
- R10: While `m_bvalid` or `m_rvalid` is 1 and the matching master ready is 0, the valid and the status stay unchanged. On the read side the data also stays unchanged.
- R11: A forwarded request returns the slave's 2-bit status unchanged (OKAY 2'b00, EXOKAY 2'b01, SLVERR 2'b10, DECERR 2'b11).
- R12: A write holds `s_wvalid` and `s_waddr` until the slave raises `s_wready`. `s_bready` rises only after that acceptance, and `m_bvalid` does not rise until the slave's `s_bvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_wreq_valid | input | 1 | Master write request (address and data) valid |
| m_wreq_ready | output | 1 | Write request accepted |
| m_waddr | input | 32 | Write byte address |
| m_wdata | input | 128 | Write data |
| m_wstrb | input | 16 | Write byte strobes |
| m_bvalid | output | 1 | Write status valid |
| m_bready | input | 1 | Master takes write status |
| m_bresp | output | 2 | Write status |
| m_arvalid | input | 1 | Read request valid |
| m_arready | output | 1 | Read request accepted |
| m_araddr | input | 32 | Read byte address |
| m_rvalid | output | 1 | Read result valid |
| m_rready | input | 1 | Master takes read result |
| m_rdata | output | 128 | Read data |
| m_rresp | output | 2 | Read status |
| s_wvalid | output | 5 | Per-slave write valid, bit = slave index |
| s_wready | input | 5 | Per-slave write accept |
| s_waddr | output | 32 | Write address to slaves |
| s_wdata_wide | output | 128 | Write data to ROM and DRAM |
| s_wstrb_wide | output | 16 | Write strobe to ROM and DRAM |
| s_wdata_nar | output | 32 | Lane-selected write data to 32-bit slaves |
| s_wstrb_nar | output | 4 | Lane-selected strobe to 32-bit slaves |
| s_bvalid | input | 5 | Per-slave write status valid |
| s_bready | output | 5 | Per-slave write status accept |
| s_bresp | input | 10 | Per-slave write status, 2 bits per index |
| s_arvalid | output | 5 | Per-slave read address valid |
| s_arready | input | 5 | Per-slave read address accept |
| s_araddr | output | 32 | Read address to slaves |
| s_rvalid | input | 5 | Per-slave read data valid |
| s_rready | output | 5 | Per-slave read data accept |
| s_rdata_wide | input | 256 | Read data: ROM in [127:0], DRAM in [255:128] |
| s_rdata_nar | input | 96 | Read data: timer [31:0], interrupt controller [63:32], UART [95:64] |
| s_rresp | input | 10 | Per-slave read status, 2 bits per index |

## Verification
The properties assume that the slaves behave as handshake partners. A slave raises `s_bvalid` or `s_rvalid` only for a request it has accepted, and holds that valid until the router takes it. The master holds its request fields steady while its valid waits for ready. The bench slave models meet these assumptions by construction. They set a per-slave pending bit only on an observed handshake and clear it only on the matching response handshake. Every master-side driver in the bench holds its fields until the accepting edge has passed.

// File: rtl/mmio_router_pkg.sv
package mmio_router_pkg;

    localparam int ADDR_W   = 32;
    localparam int WIDE_W   = 128;
    localparam int NARROW_W = 32;
    localparam int NSLV     = 5;
    localparam int NWIDE    = 2;
    localparam int NNARROW  = 3;
    localparam int RESP_W   = 2;
    localparam int WSTRB_W  = WIDE_W / 8;
    localparam int NSTRB_W  = NARROW_W / 8;
    localparam int LANES    = WIDE_W / NARROW_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int LANE_LSB = $clog2(NSTRB_W);

    // slave index order is visible at the ports
    typedef enum logic [2:0] {
        TGT_ROM   = 3'd0,
        TGT_CLINT = 3'd1,
        TGT_PLIC  = 3'd2,
        TGT_UART  = 3'd3,
        TGT_DRAM  = 3'd4,
        TGT_NONE  = 3'd5
    } tgt_e;

    localparam logic [RESP_W-1:0] RESP_OKAY   = 2'b00;
    localparam logic [RESP_W-1:0] RESP_DECERR = 2'b11;

    function automatic logic tgt_is_wide(input tgt_e t);
        return (t == TGT_ROM) || (t == TGT_DRAM);
    endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
    import mmio_router_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DRAM_LAST = 32'h87FF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt
);

    localparam logic [ADDR_W-1:0] ROM_LO   = 32'h0001_0000;
    localparam logic [ADDR_W-1:0] ROM_HI   = 32'h0001_1FFF;
    localparam logic [ADDR_W-1:0] CLINT_LO = 32'h0200_0000;
    localparam logic [ADDR_W-1:0] CLINT_HI = 32'h020B_FFFF;
    localparam logic [ADDR_W-1:0] PLIC_LO  = 32'h0C00_0000;
    localparam logic [ADDR_W-1:0] PLIC_HI  = 32'h0CFF_FFFF;
    localparam logic [ADDR_W-1:0] UART_LO  = 32'h1000_0000;
    localparam logic [ADDR_W-1:0] UART_HI  = 32'h1000_00FF;
    localparam logic [ADDR_W-1:0] DRAM_LO  = 32'h8000_0000;

    always_comb begin
        tgt = TGT_NONE;
        if (addr >= ROM_LO && addr <= ROM_HI) begin
            tgt = TGT_ROM;
        end else if (addr >= CLINT_LO && addr <= CLINT_HI) begin
            tgt = TGT_CLINT;
        end else if (addr >= PLIC_LO && addr <= PLIC_HI) begin
            tgt = TGT_PLIC;
        end else if (addr >= UART_LO && addr <= UART_HI) begin
            tgt = TGT_UART;
        end else if (addr >= DRAM_LO && addr <= DRAM_LAST) begin
            tgt = TGT_DRAM;
        end
    end

endmodule

// File: rtl/mmio_wr_fsm.sv
module mmio_wr_fsm
    import mmio_router_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [WIDE_W-1:0]        req_data,
    input  logic [WSTRB_W-1:0]       req_strb,
    input  tgt_e                     req_tgt,
    output logic                     resp_valid,
    input  logic                     resp_ready,
    output logic [RESP_W-1:0]        resp_code,
    output logic [NSLV-1:0]          s_wvalid,
    input  logic [NSLV-1:0]          s_wready,
    output logic [ADDR_W-1:0]        s_waddr,
    output logic [WIDE_W-1:0]        s_wdata_wide,
    output logic [WSTRB_W-1:0]       s_wstrb_wide,
    output logic [NARROW_W-1:0]      s_wdata_nar,
    output logic [NSTRB_W-1:0]       s_wstrb_nar,
    input  logic [NSLV-1:0]          s_bvalid,
    output logic [NSLV-1:0]          s_bready,
    input  logic [NSLV*RESP_W-1:0]   s_bresp
);

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_CLINT,
        WS_PLIC,
        WS_UART,
        WS_DRAM,
        WS_RESP
    } wst_e;

    wst_e                st_q, st_d;
    logic                sent_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WIDE_W-1:0]   data_q;
    logic [WSTRB_W-1:0]  strb_q;
    logic [RESP_W-1:0]   resp_q;
    logic                waiting;
    logic [2:0]          slot;
    logic [LANE_W-1:0]   lane;

    // which slave a wait state belongs to
    always_comb begin
        waiting = 1'b1;
        slot    = 3'(TGT_ROM);
        unique case (st_q)
            WS_CLINT: slot = 3'(TGT_CLINT);
            WS_PLIC:  slot = 3'(TGT_PLIC);
            WS_UART:  slot = 3'(TGT_UART);
            WS_DRAM:  slot = 3'(TGT_DRAM);
            default:  waiting = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_IDLE: begin
                if (req_valid) begin
                    unique case (req_tgt)
                        TGT_CLINT: st_d = WS_CLINT;
                        TGT_PLIC:  st_d = WS_PLIC;
                        TGT_UART:  st_d = WS_UART;
                        TGT_DRAM:  st_d = WS_DRAM;
                        default:   st_d = WS_RESP;
                    endcase
                end
            end
            WS_CLINT, WS_PLIC, WS_UART, WS_DRAM: begin
                if (sent_q && s_bvalid[slot]) st_d = WS_RESP;
            end
            WS_RESP: begin
                if (resp_ready) st_d = WS_IDLE;
            end
            default: st_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
            resp_q <= RESP_OKAY;
        end else begin
            if (st_q == WS_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_data;
                strb_q <= req_strb;
                sent_q <= 1'b0;
                resp_q <= (req_tgt == TGT_ROM || req_tgt == TGT_NONE) ? RESP_DECERR : RESP_OKAY;
            end
            if (waiting && !sent_q && s_wready[slot]) sent_q <= 1'b1;
            if (waiting && sent_q && s_bvalid[slot]) resp_q <= s_bresp[{slot, 1'b0} +: RESP_W];
        end
    end

    assign lane = addr_q[LANE_LSB +: LANE_W];

    always_comb begin
        req_ready    = (st_q == WS_IDLE);
        resp_valid   = (st_q == WS_RESP);
        resp_code    = resp_q;
        s_wvalid     = '0;
        s_bready     = '0;
        if (waiting) begin
            s_wvalid[slot] = !sent_q;
            s_bready[slot] = sent_q;
        end
        s_waddr      = addr_q;
        s_wdata_wide = data_q;
        s_wstrb_wide = strb_q;
        s_wdata_nar  = '0;
        s_wstrb_nar  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane == LANE_W'(k)) begin
                s_wdata_nar = data_q[k*NARROW_W +: NARROW_W];
                s_wstrb_nar = strb_q[k*NSTRB_W +: NSTRB_W];
            end
        end
    end

endmodule

// File: rtl/mmio_rd_fsm.sv
module mmio_rd_fsm
    import mmio_router_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  tgt_e                       req_tgt,
    output logic                       resp_valid,
    input  logic                       resp_ready,
    output logic [WIDE_W-1:0]          resp_data,
    output logic [RESP_W-1:0]          resp_code,
    output logic [NSLV-1:0]            s_arvalid,
    input  logic [NSLV-1:0]            s_arready,
    output logic [ADDR_W-1:0]          s_araddr,
    input  logic [NSLV-1:0]            s_rvalid,
    output logic [NSLV-1:0]            s_rready,
    input  logic [NWIDE*WIDE_W-1:0]    s_rdata_wide,
    input  logic [NNARROW*NARROW_W-1:0] s_rdata_nar,
    input  logic [NSLV*RESP_W-1:0]     s_rresp
);

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_ADDR,
        RS_DATA,
        RS_HOLD
    } rst_e;

    rst_e                st_q, st_d;
    tgt_e                tgt_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WIDE_W-1:0]   data_q;
    logic [RESP_W-1:0]   resp_q;
    logic [2:0]          slot;
    logic [LANE_W-1:0]   lane;
    logic [NARROW_W-1:0] nar_word;
    logic [WIDE_W-1:0]   wide_word;
    logic [WIDE_W-1:0]   ret_data;

    assign slot = 3'(tgt_q);
    assign lane = addr_q[LANE_LSB +: LANE_W];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE: if (req_valid) st_d = (req_tgt == TGT_NONE) ? RS_HOLD : RS_ADDR;
            RS_ADDR: if (s_arready[slot]) st_d = RS_DATA;
            RS_DATA: if (s_rvalid[slot]) st_d = RS_HOLD;
            RS_HOLD: if (resp_ready) st_d = RS_IDLE;
            default: st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    // returned data: wide slaves pass through, narrow ones land on their lane
    always_comb begin
        wide_word = (tgt_q == TGT_DRAM) ? s_rdata_wide[WIDE_W +: WIDE_W] : s_rdata_wide[0 +: WIDE_W];
        unique case (tgt_q)
            TGT_CLINT: nar_word = s_rdata_nar[0 +: NARROW_W];
            TGT_PLIC:  nar_word = s_rdata_nar[NARROW_W +: NARROW_W];
            TGT_UART:  nar_word = s_rdata_nar[2*NARROW_W +: NARROW_W];
            default:   nar_word = '0;
        endcase
        ret_data = '0;
        if (tgt_is_wide(tgt_q)) begin
            ret_data = wide_word;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane == LANE_W'(k)) ret_data[k*NARROW_W +: NARROW_W] = nar_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= TGT_NONE;
            addr_q <= '0;
            data_q <= '0;
            resp_q <= RESP_OKAY;
        end else begin
            if (st_q == RS_IDLE && req_valid) begin
                tgt_q  <= req_tgt;
                addr_q <= req_addr;
                data_q <= '0;
                resp_q <= (req_tgt == TGT_NONE) ? RESP_DECERR : RESP_OKAY;
            end
            if (st_q == RS_DATA && s_rvalid[slot]) begin
                data_q <= ret_data;
                resp_q <= s_rresp[{slot, 1'b0} +: RESP_W];
            end
        end
    end

    always_comb begin
        req_ready  = (st_q == RS_IDLE);
        resp_valid = (st_q == RS_HOLD);
        resp_data  = data_q;
        resp_code  = resp_q;
        s_araddr   = addr_q;
        s_arvalid  = '0;
        s_rready   = '0;
        if (st_q == RS_ADDR) s_arvalid[slot] = 1'b1;
        if (st_q == RS_DATA) s_rready[slot]  = 1'b1;
    end

endmodule

// File: rtl/mmio_router.sv
module mmio_router
    import mmio_router_pkg::*;
#(
    parameter bit DRAM_LARGE = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         m_wreq_valid,
    output logic                         m_wreq_ready,
    input  logic [ADDR_W-1:0]            m_waddr,
    input  logic [WIDE_W-1:0]            m_wdata,
    input  logic [WSTRB_W-1:0]           m_wstrb,
    output logic                         m_bvalid,
    input  logic                         m_bready,
    output logic [RESP_W-1:0]            m_bresp,
    input  logic                         m_arvalid,
    output logic                         m_arready,
    input  logic [ADDR_W-1:0]            m_araddr,
    output logic                         m_rvalid,
    input  logic                         m_rready,
    output logic [WIDE_W-1:0]            m_rdata,
    output logic [RESP_W-1:0]            m_rresp,
    output logic [NSLV-1:0]              s_wvalid,
    input  logic [NSLV-1:0]              s_wready,
    output logic [ADDR_W-1:0]            s_waddr,
    output logic [WIDE_W-1:0]            s_wdata_wide,
    output logic [WSTRB_W-1:0]           s_wstrb_wide,
    output logic [NARROW_W-1:0]          s_wdata_nar,
    output logic [NSTRB_W-1:0]           s_wstrb_nar,
    input  logic [NSLV-1:0]              s_bvalid,
    output logic [NSLV-1:0]              s_bready,
    input  logic [NSLV*RESP_W-1:0]       s_bresp,
    output logic [NSLV-1:0]              s_arvalid,
    input  logic [NSLV-1:0]              s_arready,
    output logic [ADDR_W-1:0]            s_araddr,
    input  logic [NSLV-1:0]              s_rvalid,
    output logic [NSLV-1:0]              s_rready,
    input  logic [NWIDE*WIDE_W-1:0]      s_rdata_wide,
    input  logic [NNARROW*NARROW_W-1:0]  s_rdata_nar,
    input  logic [NSLV*RESP_W-1:0]       s_rresp
);

    localparam logic [ADDR_W-1:0] DRAM_LAST = DRAM_LARGE ? 32'h8FFF_FFFF : 32'h87FF_FFFF;

    tgt_e wr_tgt, rd_tgt;

    mmio_addr_decode #(.DRAM_LAST(DRAM_LAST)) u_wr_dec (
        .addr (m_waddr),
        .tgt  (wr_tgt)
    );

    mmio_addr_decode #(.DRAM_LAST(DRAM_LAST)) u_rd_dec (
        .addr (m_araddr),
        .tgt  (rd_tgt)
    );

    mmio_wr_fsm u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (m_wreq_valid),
        .req_ready    (m_wreq_ready),
        .req_addr     (m_waddr),
        .req_data     (m_wdata),
        .req_strb     (m_wstrb),
        .req_tgt      (wr_tgt),
        .resp_valid   (m_bvalid),
        .resp_ready   (m_bready),
        .resp_code    (m_bresp),
        .s_wvalid     (s_wvalid),
        .s_wready     (s_wready),
        .s_waddr      (s_waddr),
        .s_wdata_wide (s_wdata_wide),
        .s_wstrb_wide (s_wstrb_wide),
        .s_wdata_nar  (s_wdata_nar),
        .s_wstrb_nar  (s_wstrb_nar),
        .s_bvalid     (s_bvalid),
        .s_bready     (s_bready),
        .s_bresp      (s_bresp)
    );

    mmio_rd_fsm u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (m_arvalid),
        .req_ready    (m_arready),
        .req_addr     (m_araddr),
        .req_tgt      (rd_tgt),
        .resp_valid   (m_rvalid),
        .resp_ready   (m_rready),
        .resp_data    (m_rdata),
        .resp_code    (m_rresp),
        .s_arvalid    (s_arvalid),
        .s_arready    (s_arready),
        .s_araddr     (s_araddr),
        .s_rvalid     (s_rvalid),
        .s_rready     (s_rready),
        .s_rdata_wide (s_rdata_wide),
        .s_rdata_nar  (s_rdata_nar),
        .s_rresp      (s_rresp)
    );

endmodule

// File: rtl/mmio_router_chk.sv
module mmio_router_chk
    import mmio_router_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  m_wreq_valid,
    input logic                  m_wreq_ready,
    input logic                  m_bvalid,
    input logic                  m_bready,
    input logic [RESP_W-1:0]     m_bresp,
    input logic                  m_arvalid,
    input logic                  m_arready,
    input logic                  m_rvalid,
    input logic                  m_rready,
    input logic [WIDE_W-1:0]     m_rdata,
    input logic [RESP_W-1:0]     m_rresp,
    input logic [NSLV-1:0]       s_wvalid,
    input logic [NSLV-1:0]       s_wready,
    input logic [ADDR_W-1:0]     s_waddr,
    input logic [NSLV-1:0]       s_bready,
    input logic [NSLV-1:0]       s_arvalid
);

    assert_wvalid_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_wvalid) && $onehot0(s_arvalid));

    assert_rom_not_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_wvalid[TGT_ROM]);

    assert_wready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wreq_valid && m_wreq_ready) |=> !m_wreq_ready);

    assert_arready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_arready) |=> !m_arready);

    assert_bresp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && !m_bready) |=> (m_bvalid && $stable(m_bresp)));

    assert_rresp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && !m_rready) |=> (m_rvalid && $stable(m_rresp) && $stable(m_rdata)));

    assert_wvalid_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_wvalid != '0) && ((s_wvalid & s_wready) == '0)) |=> ($stable(s_wvalid) && $stable(s_waddr)));

    assert_bready_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bready != '0) |-> (s_wvalid == '0));

endmodule

bind mmio_router mmio_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .m_wreq_valid (m_wreq_valid),
    .m_wreq_ready (m_wreq_ready),
    .m_bvalid     (m_bvalid),
    .m_bready     (m_bready),
    .m_bresp      (m_bresp),
    .m_arvalid    (m_arvalid),
    .m_arready    (m_arready),
    .m_rvalid     (m_rvalid),
    .m_rready     (m_rready),
    .m_rdata      (m_rdata),
    .m_rresp      (m_rresp),
    .s_wvalid     (s_wvalid),
    .s_wready     (s_wready),
    .s_waddr      (s_waddr),
    .s_bready     (s_bready),
    .s_arvalid    (s_arvalid)
);

// File: tb/tb_mmio_router.sv
`timescale 1ns/1ps
module tb_mmio_router;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_wreq_valid = 1'b0;
    logic         m_wreq_ready;
    logic [31:0]  m_waddr = '0;
    logic [127:0] m_wdata = '0;
    logic [15:0]  m_wstrb = '0;
    logic         m_bvalid;
    logic         m_bready = 1'b0;
    logic [1:0]   m_bresp;
    logic         m_arvalid = 1'b0;
    logic         m_arready;
    logic [31:0]  m_araddr = '0;
    logic         m_rvalid;
    logic         m_rready = 1'b0;
    logic [127:0] m_rdata;
    logic [1:0]   m_rresp;
    logic [4:0]   s_wvalid, s_wready, s_bvalid, s_bready;
    logic [4:0]   s_arvalid, s_arready, s_rvalid, s_rready;
    logic [31:0]  s_waddr, s_araddr;
    logic [127:0] s_wdata_wide;
    logic [15:0]  s_wstrb_wide;
    logic [31:0]  s_wdata_nar;
    logic [3:0]   s_wstrb_nar;
    logic [9:0]   s_bresp, s_rresp;
    logic [255:0] s_rdata_wide;
    logic [95:0]  s_rdata_nar;

    always #10 clk = ~clk;

    mmio_router dut (.*);

    // bench slave models
    logic         w_stall = 1'b0, b_block = 1'b0;
    logic [1:0]   bresp_cfg = 2'b00, rresp_cfg = 2'b00;
    logic [4:0]   b_pend, r_pend;
    logic [31:0]  r_addr [5];
    logic [31:0]  seen_addr [5];
    logic [127:0] seen_data [5];
    logic [15:0]  seen_strb [5];
    int           wr_hits [5];
    int           rd_hits [5];

    assign s_wready  = {5{!w_stall}};
    assign s_arready = 5'b11111;
    assign s_bvalid  = b_pend & {5{!b_block}};
    assign s_rvalid  = r_pend;
    assign s_bresp   = {5{bresp_cfg}};
    assign s_rresp   = {5{rresp_cfg}};

    function automatic logic [31:0] rd_word(input int i, input logic [31:0] a);
        return a ^ (32'(i) << 24) ^ 32'h5A00_0000;
    endfunction

    function automatic logic [127:0] wide_word(input int i, input logic [31:0] a);
        logic [31:0] w;
        w = rd_word(i, a);
        return {w + 32'd3, w + 32'd2, w + 32'd1, w};
    endfunction

    always_comb begin
        s_rdata_wide = {wide_word(4, r_addr[4]), wide_word(0, r_addr[0])};
        s_rdata_nar  = {rd_word(3, r_addr[3]), rd_word(2, r_addr[2]), rd_word(1, r_addr[1])};
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            b_pend <= '0;
            r_pend <= '0;
            for (int i = 0; i < 5; i++) begin
                wr_hits[i] <= 0;
                rd_hits[i] <= 0;
                r_addr[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (s_wvalid[i] && s_wready[i]) begin
                    b_pend[i]    <= 1'b1;
                    seen_addr[i] <= s_waddr;
                    seen_data[i] <= (i == 0 || i == 4) ? s_wdata_wide : {96'b0, s_wdata_nar};
                    seen_strb[i] <= (i == 0 || i == 4) ? s_wstrb_wide : {12'b0, s_wstrb_nar};
                    wr_hits[i]   <= wr_hits[i] + 1;
                end else if (s_bvalid[i] && s_bready[i]) begin
                    b_pend[i] <= 1'b0;
                end
                if (s_arvalid[i] && s_arready[i]) begin
                    r_pend[i]  <= 1'b1;
                    r_addr[i]  <= s_araddr;
                    rd_hits[i] <= rd_hits[i] + 1;
                end else if (s_rvalid[i] && s_rready[i]) begin
                    r_pend[i] <= 1'b0;
                end
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [127:0] d, input logic [15:0] s,
                            input int hold, output logic [1:0] resp, output bit unstable);
        @(negedge clk);
        m_wreq_valid = 1'b1; m_waddr = a; m_wdata = d; m_wstrb = s; m_bready = 1'b0;
        while (!m_wreq_ready) @(negedge clk);
        @(negedge clk);
        m_wreq_valid = 1'b0;
        while (!m_bvalid) @(negedge clk);
        resp = m_bresp;
        unstable = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            if (!m_bvalid || m_bresp != resp) unstable = 1'b1;
        end
        m_bready = 1'b1;
        @(negedge clk);
        m_bready = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] a, input int hold, output logic [1:0] resp,
                           output logic [127:0] data, output bit unstable);
        @(negedge clk);
        m_arvalid = 1'b1; m_araddr = a; m_rready = 1'b0;
        while (!m_arready) @(negedge clk);
        @(negedge clk);
        m_arvalid = 1'b0;
        while (!m_rvalid) @(negedge clk);
        resp = m_rresp;
        data = m_rdata;
        unstable = 1'b0;
        repeat (hold) begin
            @(negedge clk);
            if (!m_rvalid || m_rresp != resp || m_rdata != data) unstable = 1'b1;
        end
        m_rready = 1'b1;
        @(negedge clk);
        m_rready = 1'b0;
    endtask

    // {is_write, expected slave index (5 = none), address}
    localparam int NVEC = 22;
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b1, 3'd5, 32'h0001_0000},
        {1'b1, 3'd1, 32'h0200_0004},
        {1'b1, 3'd1, 32'h020B_FFFC},
        {1'b1, 3'd5, 32'h020C_0000},
        {1'b1, 3'd2, 32'h0C00_0008},
        {1'b1, 3'd2, 32'h0CFF_FFF0},
        {1'b1, 3'd3, 32'h1000_0000},
        {1'b1, 3'd3, 32'h1000_00FC},
        {1'b1, 3'd5, 32'h1000_0100},
        {1'b1, 3'd4, 32'h8000_0000},
        {1'b1, 3'd4, 32'h87FF_FFF0},
        {1'b1, 3'd5, 32'h8800_0000},
        {1'b1, 3'd5, 32'h0000_0000},
        {1'b0, 3'd0, 32'h0001_0000},
        {1'b0, 3'd0, 32'h0001_1FF0},
        {1'b0, 3'd5, 32'h0001_2000},
        {1'b0, 3'd1, 32'h0200_0008},
        {1'b0, 3'd2, 32'h0C00_0004},
        {1'b0, 3'd3, 32'h1000_000C},
        {1'b0, 3'd4, 32'h8000_0010},
        {1'b0, 3'd5, 32'hFFFF_FFF0},
        {1'b0, 3'd4, 32'h87FF_FFF0}
    };

    function automatic int sum5(input int h [5]);
        return h[0] + h[1] + h[2] + h[3] + h[4];
    endfunction

    initial begin
        logic [1:0]   resp;
        logic [127:0] data;
        bit           unst;
        int           tot0;
        int           hit0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(m_wreq_ready && m_arready, "R1", "readies in reset", {m_wreq_ready, m_arready}, 2'b11);
        chk(!m_bvalid && !m_rvalid && s_wvalid == 0 && s_arvalid == 0, "R1", "valids in reset",
            {m_bvalid, m_rvalid, s_wvalid, s_arvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_wreq_ready && m_arready && !m_bvalid && !m_rvalid, "R1", "state after reset",
            {m_wreq_ready, m_arready, m_bvalid, m_rvalid}, 4'b1100);

        // table walk: routing, lanes, DECERR, DRAM limit
        for (int v = 0; v < NVEC; v++) begin
            logic        isw;
            logic [2:0]  tg;
            logic [31:0] a;
            logic [1:0]  ln;
            logic [1:0]  eresp;
            logic [127:0] d;
            isw = VEC[v][35];
            tg  = VEC[v][34:32];
            a   = VEC[v][31:0];
            ln  = a[3:2];
            eresp = (tg == 3'd5) ? 2'b11 : 2'b00;
            if (isw) begin
                d = {a ^ 32'h3333_3333, a ^ 32'h2222_2222, a ^ 32'h1111_1111, a ^ 32'hD000_0000};
                tot0 = sum5(wr_hits);
                hit0 = (tg < 3'd5) ? wr_hits[tg] : 0;
                do_write(a, d, 16'h8421, 0, resp, unst);
                chk(resp == eresp, (tg == 3'd5) ? "R8" : "R2", "write status", resp, eresp);
                if (tg == 3'd5) begin
                    chk(sum5(wr_hits) == tot0, "R8", "write not forwarded", sum5(wr_hits) - tot0, 0);
                end else begin
                    chk(wr_hits[tg] == hit0 + 1 && sum5(wr_hits) == tot0 + 1, "R5", "one slave written",
                        sum5(wr_hits) - tot0, 1);
                    chk(seen_addr[tg] == a, "R4", "forwarded write address", seen_addr[tg], a);
                    if (tg == 3'd4) begin
                        chk(seen_data[tg] == d && seen_strb[tg] == 16'h8421, "R4", "wide data and strobe",
                            seen_data[tg], d);
                    end else begin
                        chk(seen_data[tg][31:0] == d[ln*32 +: 32], "R6", "narrow lane data",
                            seen_data[tg][31:0], d[ln*32 +: 32]);
                        chk(seen_strb[tg][3:0] == (4'b0001 << ln), "R6", "narrow lane strobe",
                            seen_strb[tg][3:0], 4'b0001 << ln);
                    end
                end
            end else begin
                logic [127:0] edata;
                tot0 = sum5(rd_hits);
                do_read(a, 0, resp, data, unst);
                edata = '0;
                if (tg == 3'd0 || tg == 3'd4) edata = wide_word(int'(tg), a);
                else if (tg != 3'd5) edata[ln*32 +: 32] = rd_word(int'(tg), a);
                chk(resp == eresp, (tg == 3'd5) ? "R8" : "R2", "read status", resp, eresp);
                chk(data == edata, (tg == 3'd5) ? "R8" : "R7", "read data", data, edata);
                chk(sum5(rd_hits) == tot0 + ((tg == 3'd5) ? 0 : 1), "R5", "read fan-out",
                    sum5(rd_hits) - tot0, (tg == 3'd5) ? 0 : 1);
            end
        end

        // R3: first byte past the default DRAM limit reads as unmapped
        do_read(32'h8800_0000, 0, resp, data, unst);
        chk(resp == 2'b11 && data == 0, "R3", "read above DRAM limit", resp, 2'b11);

        // R11: slave status passes through unchanged
        bresp_cfg = 2'b10;
        do_write(32'h1000_0010, {4{32'hA5A5_0F0F}}, 16'hFFFF, 0, resp, unst);
        chk(resp == 2'b10, "R11", "write SLVERR forwarded", resp, 2'b10);
        bresp_cfg = 2'b00;
        rresp_cfg = 2'b01;
        do_read(32'h8000_0100, 0, resp, data, unst);
        chk(resp == 2'b01, "R11", "read EXOKAY forwarded", resp, 2'b01);
        rresp_cfg = 2'b00;

        // R10: status held while master is not ready
        bresp_cfg = 2'b10;
        do_write(32'h0C00_0000, '1, 16'h000F, 5, resp, unst);
        chk(!unst && resp == 2'b10, "R10", "write status held", unst, 0);
        bresp_cfg = 2'b00;
        do_read(32'h0200_0004, 4, resp, data, unst);
        chk(!unst, "R10", "read result held", unst, 0);

        // R12 / R9: write offer held under slave stall, response waits for slave
        @(negedge clk);
        w_stall = 1'b1; b_block = 1'b1;
        m_wreq_valid = 1'b1; m_waddr = 32'h0200_0010; m_wdata = '1; m_wstrb = '1; m_bready = 1'b1;
        @(negedge clk);
        m_wreq_valid = 1'b0;
        chk(!m_wreq_ready, "R9", "ready low after accept", m_wreq_ready, 0);
        for (int c = 0; c < 3; c++) begin
            chk(s_wvalid == 5'b00010 && s_bready == 0, "R12", "offer held under stall",
                {s_wvalid, s_bready}, {5'b00010, 5'b0});
            @(negedge clk);
        end
        w_stall = 1'b0;
        @(negedge clk);
        chk(s_wvalid == 0 && s_bready == 5'b00010, "R12", "bready after acceptance",
            {s_wvalid, s_bready}, {5'b0, 5'b00010});
        for (int c = 0; c < 5; c++) begin
            chk(!m_bvalid && !m_wreq_ready, "R12", "no status before slave responds",
                {m_bvalid, m_wreq_ready}, 0);
            @(negedge clk);
        end
        b_block = 1'b0;
        @(negedge clk);
        chk(m_bvalid && m_bresp == 2'b00, "R12", "status after slave response", {m_bvalid, m_bresp}, 3'b100);
        chk(!m_wreq_ready, "R9", "ready low until status taken", m_wreq_ready, 0);
        @(negedge clk);
        m_bready = 1'b0;
        chk(m_wreq_ready && !m_bvalid, "R9", "ready back after handshake", {m_wreq_ready, m_bvalid}, 2'b10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=hang expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule